// File: doc/BRIEF.md
# Load/Store Byte-Lane Aligner

The block sits between an integer register file and a 64-bit memory data path. It takes a base register value and a 16-bit displacement and forms the byte address of the access. It places store data onto the correct byte lanes of the memory word with matching write strobes. For a load, it pulls the addressed bytes out of the memory word and widens them to a full 64-bit register value. A mode input chooses big-endian or little-endian lane numbering for each request. The choice applies to every access width, from one byte up to eight bytes.

A request is one cycle with `req_valid` high. All results are registered and appear on the next clock edge with `out_valid`. The memory read word is given together with the request, so the block does no memory timing of its own. An access whose address is not a multiple of its width is flagged as misaligned. A misaligned access writes no bytes and does not write the register file. A load aimed at register 0 never raises the register write enable, because register 0 always reads as zero.

Top module: `lsa_aligner`

## Requirements
- R1: `eff_addr` equals `base_val` plus `disp`, where `disp` is sign-extended from 16 to 64 bits and the sum wraps modulo 2^64.
- R2: With `disp` zero, `eff_addr` equals `base_val` (register-indirect). With `base_val` zero, `eff_addr` is the sign-extended displacement (absolute addressing).
- R3: An access whose address is not a multiple of its width in bytes sets `misalign`. It also forces `wr_strb` to zero and `reg_we` to 0.
- R4: An aligned store sets exactly N adjacent strobe bits, where N = 1 << `req_size`. `req_size` encodes 0 = byte, 1 = halfword, 2 = word, 3 = doubleword. The low N bytes of `st_data` appear in the strobed lanes, and the same N bytes are repeated across the whole `wr_data` word.
- R5: `wr_strb[k]` and bits [8k+7:8k] of the memory words form lane k, and the byte offset is `eff_addr[2:0]`.
  - In little-endian mode (`req_big_endian` = 0), the first lane is the offset, and value byte i sits in lane offset+i.
  - In big-endian mode, the first lane is 8 − N − offset, and the most significant value byte sits at the lowest address, which is lane 7 − offset.
- R6: An aligned load with `req_signed` = 1 gives the selected bytes in the low bits of `ld_result`, with the top bit of those bytes copied into all higher bits.
- R7: An aligned load with `req_signed` = 0 gives the selected bytes in the low bits of `ld_result` and zeros above them.
- R8: `reg_we` is 1 exactly for an aligned load whose `req_dest` is not zero.
- R9: `out_valid` and all results follow a request by one clock. While reset is held, and while `out_valid` is 0, `wr_strb` is zero and `reg_we` is 0.
- R10: A store never raises `reg_we`, and a load never raises any `wr_strb` bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Access width: 0 byte, 1 half, 2 word, 3 double |
| req_signed | input | 1 | Load extension: 1 sign, 0 zero |
| req_big_endian | input | 1 | Lane numbering mode: 1 big-endian, 0 little-endian |
| req_dest | input | 5 | Destination register index of a load |
| base_val | input | 64 | Base register value |
| disp | input | 16 | Signed displacement |
| st_data | input | 64 | Register value to store (low bytes used) |
| mem_rdata | input | 64 | Memory word for a load |
| out_valid | output | 1 | Results below are valid |
| eff_addr | output | 64 | Effective byte address |
| wr_strb | output | 8 | Per-lane byte write enables |
| wr_data | output | 64 | Lane-placed store data |
| ld_result | output | 64 | Extended load value |
| reg_we | output | 1 | Register file write enable |
| misalign | output | 1 | Alignment error |

## Verification
The hardest case is a big-endian access of a narrow width at a high offset. Here the lane order is reversed, and an off-by-one lane error leaves most other cases correct. The bench drives every combination of width, offset and endian mode for both loads and stores. Half of those combinations are misaligned, so the error path is reached in both modes. Memory words are chosen with the top selected bit both set and clear, which separates sign extension from zero extension. Separate requests use a negative displacement, a zero base, and register 0 as a load destination.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

  localparam int unsigned LSA_DATA_W = 64;
  localparam int unsigned LSA_LANES  = LSA_DATA_W / 8;
  localparam int unsigned LSA_OFF_W  = $clog2(LSA_LANES);

  typedef enum logic [1:0] {
    ACC_BYTE = 2'd0,
    ACC_HALF = 2'd1,
    ACC_WORD = 2'd2,
    ACC_DBL  = 2'd3
  } acc_size_e;

  typedef logic [LSA_OFF_W-1:0]  lane_t;
  typedef logic [LSA_OFF_W:0]    nbytes_t;
  typedef logic [LSA_LANES-1:0]  strb_t;
  typedef logic [LSA_DATA_W-1:0] word_t;

  // Number of bytes touched by an access of the given size.
  function automatic nbytes_t size_bytes(acc_size_e s);
    nbytes_t one;
    one = nbytes_t'(1);
    return one << s;
  endfunction

  // First lane occupied by the access.
  function automatic lane_t lane_of(lane_t off, acc_size_e s, logic be);
    nbytes_t total;
    nbytes_t far_lane;
    total    = nbytes_t'(LSA_LANES);
    far_lane = total - size_bytes(s) - {1'b0, off};
    return be ? far_lane[LSA_OFF_W-1:0] : off;
  endfunction

  // Offset not a multiple of the access width.
  function automatic logic is_misaligned(lane_t off, acc_size_e s);
    nbytes_t low_mask;
    low_mask = size_bytes(s) - nbytes_t'(1);
    return |(off & low_mask[LSA_OFF_W-1:0]);
  endfunction

  // Contiguous strobe bits starting at lane.
  function automatic strb_t strobe_mask(lane_t lane, acc_size_e s);
    logic [LSA_LANES:0] span;
    strb_t              base_bits;
    span      = (LSA_LANES+1)'(1) << size_bytes(s);
    span      = span - (LSA_LANES+1)'(1);
    base_bits = span[LSA_LANES-1:0];
    return base_bits << lane;
  endfunction

  // Keep the low bytes of a value, then sign or zero extend.
  function automatic word_t widen(word_t raw, acc_size_e s, logic sgn);
    int unsigned nbits;
    word_t       keep;
    logic        top;
    nbits = 8 * int'(size_bytes(s));
    keep  = ~({LSA_DATA_W{1'b1}} << nbits);
    if (nbits >= LSA_DATA_W) keep = {LSA_DATA_W{1'b1}};
    top   = raw[nbits-1];
    return (raw & keep) | ((sgn && top) ? ~keep : '0);
  endfunction

endpackage

// File: rtl/lsa_addr_gen.sv
module lsa_addr_gen
  import lsa_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned DISP_W = 16
) (
  input  logic [ADDR_W-1:0] base_val,
  input  logic [DISP_W-1:0] disp,
  input  acc_size_e         size,
  output logic [ADDR_W-1:0] addr,
  output lane_t             offset,
  output logic              bad_align
);
  localparam int unsigned EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] disp_ext;

  assign disp_ext  = {{EXT_W{disp[DISP_W-1]}}, disp};
  assign addr      = base_val + disp_ext;
  assign offset    = addr[LSA_OFF_W-1:0];
  assign bad_align = is_misaligned(offset, size);
endmodule

// File: rtl/lsa_store_lane.sv
module lsa_store_lane
  import lsa_pkg::*;
(
  input  logic      active,
  input  acc_size_e size,
  input  lane_t     lane,
  input  logic      bad_align,
  input  word_t     st_data,
  output strb_t     strb,
  output word_t     lane_data
);
  nbytes_t nb;
  lane_t   wrap_mask;

  assign nb        = size_bytes(size);
  assign wrap_mask = lane_t'(nb - nbytes_t'(1));
  assign strb      = (active && !bad_align) ? strobe_mask(lane, size) : '0;

  // Each lane copies the value byte it holds in a repeating pattern.
  for (genvar k = 0; k < LSA_LANES; k++) begin : g_lane
    lane_t src;
    assign src = lane_t'(k) & wrap_mask;
    assign lane_data[k*8 +: 8] = st_data[{src, 3'b000} +: 8];
  end
endmodule

// File: rtl/lsa_load_extract.sv
module lsa_load_extract
  import lsa_pkg::*;
(
  input  acc_size_e size,
  input  lane_t     lane,
  input  logic      sgn,
  input  word_t     mem_rdata,
  output word_t     result
);
  word_t shifted;

  assign shifted = mem_rdata >> {lane, 3'b000};
  assign result  = widen(shifted, size, sgn);
endmodule

// File: rtl/lsa_aligner.sv
module lsa_aligner
  import lsa_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned DISP_W = 16,
  parameter int unsigned REG_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_store,
  input  logic [1:0]        req_size,
  input  logic              req_signed,
  input  logic              req_big_endian,
  input  logic [REG_W-1:0]  req_dest,
  input  logic [ADDR_W-1:0] base_val,
  input  logic [DISP_W-1:0] disp,
  input  logic [63:0]       st_data,
  input  logic [63:0]       mem_rdata,
  output logic              out_valid,
  output logic [ADDR_W-1:0] eff_addr,
  output logic [7:0]        wr_strb,
  output logic [63:0]       wr_data,
  output logic [63:0]       ld_result,
  output logic              reg_we,
  output logic              misalign
);
  acc_size_e         size_e;
  logic [ADDR_W-1:0] addr_c;
  lane_t             offset_c;
  lane_t             lane_c;
  logic              bad_c;
  strb_t             strb_c;
  word_t             sdata_c;
  word_t             ldata_c;
  logic              we_c;

  // Registered copies, also seen by the checker.
  logic              store_q;
  acc_size_e         size_q;
  logic [REG_W-1:0]  dest_q;

  assign size_e = acc_size_e'(req_size);
  assign lane_c = lane_of(offset_c, size_e, req_big_endian);
  assign we_c   = req_valid && !req_store && !bad_c && (req_dest != '0);

  lsa_addr_gen #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_addr (
    .base_val (base_val),
    .disp     (disp),
    .size     (size_e),
    .addr     (addr_c),
    .offset   (offset_c),
    .bad_align(bad_c)
  );

  lsa_store_lane u_store (
    .active   (req_valid && req_store),
    .size     (size_e),
    .lane     (lane_c),
    .bad_align(bad_c),
    .st_data  (st_data),
    .strb     (strb_c),
    .lane_data(sdata_c)
  );

  lsa_load_extract u_load (
    .size     (size_e),
    .lane     (lane_c),
    .sgn      (req_signed),
    .mem_rdata(mem_rdata),
    .result   (ldata_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      eff_addr  <= '0;
      wr_strb   <= '0;
      wr_data   <= '0;
      ld_result <= '0;
      reg_we    <= 1'b0;
      misalign  <= 1'b0;
      store_q   <= 1'b0;
      size_q    <= ACC_BYTE;
      dest_q    <= '0;
    end else begin
      out_valid <= req_valid;
      eff_addr  <= addr_c;
      wr_strb   <= strb_c;
      wr_data   <= sdata_c;
      ld_result <= ldata_c;
      reg_we    <= we_c;
      misalign  <= req_valid && bad_c;
      store_q   <= req_valid && req_store;
      size_q    <= size_e;
      dest_q    <= req_valid ? req_dest : '0;
    end
  end
endmodule

// File: rtl/lsa_aligner_chk.sv
module lsa_aligner_chk
  import lsa_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned DISP_W = 16,
  parameter int unsigned REG_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [ADDR_W-1:0] base_val,
  input logic [DISP_W-1:0] disp,
  input logic              out_valid,
  input logic [ADDR_W-1:0] eff_addr,
  input logic [7:0]        wr_strb,
  input logic              reg_we,
  input logic              misalign,
  input logic              store_q,
  input acc_size_e         size_q,
  input logic [REG_W-1:0]  dest_q
);
  localparam int unsigned EXT_W = ADDR_W - DISP_W;

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (wr_strb == '0) && !reg_we); // R9
  AST_EA_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> eff_addr == ($past(base_val) + {{EXT_W{$past(disp[DISP_W-1])}}, $past(disp)})); // R1
  AST_MISALIGN_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && misalign) |-> (wr_strb == '0) && !reg_we); // R3
  AST_STRB_POPCOUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && store_q && !misalign) |-> ($countones(wr_strb) == (1 << size_q))); // R4
  AST_LOAD_NO_STRB: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !store_q) |-> (wr_strb == '0)); // R10
  AST_STORE_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
    store_q |-> !reg_we); // R10
  AST_ZERO_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    (dest_q == '0) |-> !reg_we); // R8
  AST_LOAD_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !store_q && !misalign && dest_q != '0) |-> reg_we); // R8
endmodule

bind lsa_aligner lsa_aligner_chk #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .REG_W(REG_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .base_val (base_val),
  .disp     (disp),
  .out_valid(out_valid),
  .eff_addr (eff_addr),
  .wr_strb  (wr_strb),
  .reg_we   (reg_we),
  .misalign (misalign),
  .store_q  (store_q),
  .size_q   (size_q),
  .dest_q   (dest_q)
);

// File: tb/lsa_aligner_tb.sv
module lsa_aligner_tb;

  typedef struct {
    logic [63:0] ea;
    logic [7:0]  strb;
    logic [63:0] data;
    logic [63:0] ld;
    logic        we;
    logic        mis;
    logic        st;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_store = 1'b0;
  logic [1:0]  req_size = '0;
  logic        req_signed = 1'b0;
  logic        req_big_endian = 1'b0;
  logic [4:0]  req_dest = '0;
  logic [63:0] base_val = '0;
  logic [15:0] disp = '0;
  logic [63:0] st_data = '0;
  logic [63:0] mem_rdata = '0;
  logic        out_valid;
  logic [63:0] eff_addr;
  logic [7:0]  wr_strb;
  logic [63:0] wr_data;
  logic [63:0] ld_result;
  logic        reg_we;
  logic        misalign;

  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;
  exp_t sb[$];

  always #4 clk = ~clk;

  lsa_aligner u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_size(req_size), .req_signed(req_signed), .req_big_endian(req_big_endian),
    .req_dest(req_dest), .base_val(base_val), .disp(disp), .st_data(st_data),
    .mem_rdata(mem_rdata), .out_valid(out_valid), .eff_addr(eff_addr),
    .wr_strb(wr_strb), .wr_data(wr_data), .ld_result(ld_result),
    .reg_we(reg_we), .misalign(misalign)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: applies one request and pushes the expected result, worked out byte by byte.
  task automatic drive(input bit st, input int sz, input bit sg, input bit be,
                       input logic [4:0] dst, input logic [63:0] b, input logic [15:0] d,
                       input logic [63:0] sd, input logic [63:0] rd, input string tag);
    exp_t e;
    int   n;
    int   off;
    n      = 1 << sz;
    e.ea   = b + {{48{d[15]}}, d};
    off    = int'(e.ea[2:0]);
    e.mis  = (off % n) != 0;
    e.st   = st;
    e.strb = '0;
    e.data = '0;
    e.ld   = '0;
    e.tag  = tag;
    if (!e.mis) begin
      for (int i = 0; i < n; i++) begin
        int ln;
        int vb;
        ln = be ? 7 - off - i : off + i;
        vb = be ? n - 1 - i : i;
        if (st) begin
          e.strb[ln] = 1'b1;
          e.data[ln*8 +: 8] = sd[vb*8 +: 8];
        end else begin
          e.ld[vb*8 +: 8] = rd[ln*8 +: 8];
        end
      end
      if (!st && sg && e.ld[n*8-1])
        for (int k = n * 8; k < 64; k++) e.ld[k] = 1'b1;
    end
    e.we = !st && !e.mis && (dst != 5'd0);
    @(negedge clk);
    req_valid      = 1'b1;
    req_store      = st;
    req_size       = 2'(sz);
    req_signed     = sg;
    req_big_endian = be;
    req_dest       = dst;
    base_val       = b;
    disp           = d;
    st_data        = sd;
    mem_rdata      = rd;
    sb.push_back(e);
  endtask

  // Monitor: compares each registered result with the oldest expected item.
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL R9 actual=out_valid expected=no result");
      end else begin
        exp_t e;
        logic [63:0] m;
        e = sb.pop_front();
        check({e.tag, " R1 eff_addr"}, eff_addr, e.ea);
        check({e.tag, " R3 misalign"}, 64'(misalign), 64'(e.mis));
        check({e.tag, " R5 wr_strb"}, 64'(wr_strb), 64'(e.strb));
        if (e.st && !e.mis) begin
          m = '0;
          for (int k = 0; k < 8; k++) if (e.strb[k]) m[k*8 +: 8] = 8'hFF;
          check({e.tag, " R4 wr_data"}, wr_data & m, e.data);
        end
        if (!e.st && !e.mis) check({e.tag, " R6 R7 ld_result"}, ld_result, e.ld);
        check({e.tag, " R8 R10 reg_we"}, 64'(reg_we), 64'(e.we));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 reset out_valid", 64'(out_valid), 64'd0);
    check("R9 reset wr_strb", 64'(wr_strb), 64'd0);
    check("R9 reset reg_we", 64'(reg_we), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 idle out_valid", 64'(out_valid), 64'd0);

    // Every width, offset and mode; R2 register-indirect (disp 0); R3 for misaligned offsets.
    for (int be = 0; be < 2; be++)
      for (int sz = 0; sz < 4; sz++)
        for (int off = 0; off < 8; off++) begin
          logic [63:0] sd;
          logic [63:0] rd;
          sd = {$urandom, $urandom};
          rd = {$urandom, $urandom};
          drive(1'b1, sz, 1'b0, be[0], 5'd3, 64'h0000_4000_0000_1000 + 64'(off), 16'h0,
                sd, rd, "R2 R4 R5 store");
          drive(1'b0, sz, off[0], be[0], 5'd7, 64'h0000_4000_0000_1000 + 64'(off), 16'h0,
                sd, 64'h8080_8080_8080_8080 ^ (rd & 64'h7F7F_7F7F_7F7F_7F7F), "R5 R6 R7 load neg");
          drive(1'b0, sz, ~off[0], be[0], 5'd9, 64'h0000_4000_0000_1000 + 64'(off), 16'h0,
                sd, rd & 64'h7F7F_7F7F_7F7F_7F7F, "R5 R6 R7 load pos");
        end

    // R1 negative displacement, R2 absolute with zero base.
    drive(1'b0, 3, 1'b0, 1'b0, 5'd1, 64'h2000, 16'hFFF8, 64'h0, 64'h1122_3344_5566_7788, "R1 neg disp");
    drive(1'b0, 2, 1'b1, 1'b1, 5'd2, 64'h0, 16'h7FF0, 64'h0, 64'hF000_0000_0000_0000, "R2 absolute");
    drive(1'b1, 1, 1'b0, 1'b0, 5'd0, 64'h0, 16'h8000, 64'hBEEF, 64'h0, "R2 absolute neg");
    drive(1'b0, 0, 1'b0, 1'b0, 5'd4, 64'hFFFF_FFFF_FFFF_FFFF, 16'h0001, 64'h0, 64'hAB, "R1 wrap");
    // R8 load into register 0: aligned but no write.
    drive(1'b0, 3, 1'b1, 1'b0, 5'd0, 64'h100, 16'h8, 64'h0, 64'hFFFF_0000_FFFF_0000, "R8 dest zero");
    drive(1'b0, 2, 1'b1, 1'b1, 5'd0, 64'h100, 16'h4, 64'h0, 64'h8000_0001_8000_0001, "R8 dest zero be");
    // R3 misaligned store in big-endian mode with nonzero disp.
    drive(1'b1, 3, 1'b0, 1'b1, 5'd5, 64'h100, 16'h3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, "R3 misaligned");

    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 drained out_valid", 64'(out_valid), 64'd0);
    check("R9 drained queue", 64'(sb.size()), 64'd0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule